// File: doc/BRIEF.md
# Run-Length Sparsity Bitstream Decoder

This block turns a packed bitstream describing where a matrix holds nonzero entries into a stream of (row, column, value) tuples. The bitstream walks the matrix positions in row-major order. A lone `1` bit marks one nonzero at the current position. A run of zero positions is written as a `0` type bit, a 3-bit length field, and then a run count made of a variable number of 4-bit nibbles. Symbols are packed back to back with no alignment, so any symbol may begin in one input word and end in the next.

The decoder takes the bitstream as a ready/valid stream of fixed-width words. It takes the nonzero values as a second ready/valid stream, and it reads the matrix width and the total nonzero count from configuration inputs that are held steady while it runs. For every nonzero it pairs the current linear position, split into row and column using the runtime column count, with the next value from the value stream. It offers the result on a ready/valid output. Once the configured number of nonzeros has been produced and the last tuple has been taken, it raises `done`.

Top module: `sparse_mark_decoder`

## Requirements
- R1: Each input word is consumed most significant bit first. Symbols continue across word boundaries with no padding or realignment.
- R2: A `1` type bit produces one output tuple that carries the current position. The position then advances by one, and the column wraps to 0 with the row incremented after column `cfg_cols-1`.
- R3: A `0` type bit is followed by a 3-bit field L, sent most significant bit first. After that come L+1 nibbles of run count N, most significant nibble first. The position advances by N, and N = 0 is legal and leaves the position unchanged.
- R4: For linear position p, the tuple carries row = p / `cfg_cols` and column = p mod `cfg_cols`. This holds when a zero run crosses one or more complete rows.
- R5: Each emitted tuple takes exactly one value from the value stream, in arrival order. `data_ready` is high for exactly one accepted value per tuple.
- R6: While `out_valid` is high and `out_ready` is low, `out_row`, `out_col` and `out_data` stay unchanged and `out_valid` stays high.
- R7: After `cfg_nnz` tuples have been produced, no further tuple appears. The bits left in the current word are dropped, `in_ready` stays low, and `done` rises once the last tuple has been accepted and stays high until reset.
- R8: With `cfg_nnz` = 0, `done` rises without any tuple being produced and without any value being taken.
- R9: After reset, `out_valid`, `data_ready` and `done` are low and `in_ready` is high.
- R10: A run count of the full 8 nibbles is decoded exactly, up to any value that fits in 31 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cols | input | COL_W | Matrix column count, nonzero, held during a decode |
| cfg_nnz | input | NNZ_W | Number of nonzeros to produce |
| in_valid | input | 1 | Bitstream word is offered |
| in_ready | output | 1 | Decoder takes the offered word |
| in_data | input | WORD_W | Packed bitstream word, MSB first |
| data_valid | input | 1 | Nonzero value is offered |
| data_ready | output | 1 | Decoder takes the offered value |
| data_in | input | DATA_W | Nonzero value |
| out_valid | output | 1 | Output tuple is valid |
| out_ready | input | 1 | Consumer takes the tuple |
| out_row | output | ROW_W | Row of the nonzero |
| out_col | output | COL_W | Column of the nonzero |
| out_data | output | DATA_W | Value paired with the nonzero |
| done | output | 1 | All nonzeros produced and drained |

## Verification
The embedded properties assume that `cfg_cols` is nonzero and that both configuration inputs stay fixed from reset release until `done`. The column-range and emission-limit checks depend on this. The bench changes these inputs only while reset is held, and every scenario uses a column count of at least one. The bitstreams are encoded in the bench from a table of zero gaps and nibble widths. The table covers bare nonzeros, zero-length runs, runs that cross several rows, and a full 8-nibble count. The value and output handshakes are stalled in repeating patterns so that stalls land mid-symbol and while a tuple is held.

// File: rtl/spd_pkg.sv
// Package: shared constants and the parser state type for the sparse
// marker decoder. Assumes run counts never exceed 31 bits.
package spd_pkg;
    localparam int RUN_W  = 32;   // width of a full count (8 nibbles)
    localparam int LEN_W  = 3;    // nibble-count field width
    localparam int NIB_W  = 4;    // bits per count nibble
    localparam int FCNT_W = 6;    // holds up to 32 pending bits

    typedef enum logic [2:0] {
        PS_TYPE,
        PS_HDR,
        PS_CNT,
        PS_SKIP,
        PS_EMIT,
        PS_DONE
    } pstate_t;
endpackage

// File: rtl/spd_bit_feeder.sv
// Bit feeder: holds one input word and hands it out one bit per take,
// most significant bit first. A new word is accepted only when the held
// word is empty. Flush drops any held bits and closes the input for good.
// Assumes take is only asserted while bit_avail is high.
module spd_bit_feeder #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              take,
    input  logic              flush,
    output logic              bit_avail,
    output logic              bit_val
);
    localparam int LEFT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] word_q;
    logic [LEFT_W-1:0] left_q;
    logic              closed_q;

    assign in_ready  = (left_q == '0) && !closed_q;
    assign bit_avail = (left_q != '0);
    assign bit_val   = word_q[WORD_W-1];

    // Load a word when empty, otherwise shift out one bit per take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            left_q   <= '0;
            closed_q <= 1'b0;
        end else if (flush) begin
            left_q   <= '0;
            closed_q <= 1'b1;
        end else if (in_valid && in_ready) begin
            word_q <= in_data;
            left_q <= LEFT_W'(WORD_W);
        end else if (take && bit_avail) begin
            word_q <= word_q << 1;
            left_q <= left_q - LEFT_W'(1);
        end
    end

    assert_take_avail_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> bit_avail);
    assert_left_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LEFT_W'(WORD_W));
    assert_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        closed_q |-> !in_ready);
endmodule

// File: rtl/spd_pos_tracker.sv
// Position tracker: keeps the current row and column. A load starts a
// multi-cycle skip of the given amount, moving a whole row remainder per
// cycle so no divider is needed. A step advances by one position.
// Assumes cols is nonzero and stable, and that step never coincides with
// a skip in progress.
module spd_pos_tracker #(
    parameter int ROW_W = 32,
    parameter int COL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COL_W-1:0]        cols,
    input  logic                    load,
    input  logic [spd_pkg::RUN_W-1:0] load_amt,
    input  logic                    step,
    output logic                    busy,
    output logic [ROW_W-1:0]        row,
    output logic [COL_W-1:0]        col
);
    import spd_pkg::*;

    logic [RUN_W-1:0] rem_q;
    logic [COL_W:0]   gap;
    logic [RUN_W-1:0] gap_ext;

    assign gap     = {1'b0, cols} - {1'b0, col};
    assign gap_ext = RUN_W'(gap);
    assign busy    = (rem_q != '0);

    // Advance the position by a pending skip or by a single step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            row   <= '0;
            col   <= '0;
        end else if (load) begin
            rem_q <= load_amt;
        end else if (busy) begin
            if (rem_q >= gap_ext) begin
                row   <= row + ROW_W'(1);
                col   <= '0;
                rem_q <= rem_q - gap_ext;
            end else begin
                col   <= col + rem_q[COL_W-1:0];
                rem_q <= '0;
            end
        end else if (step) begin
            if (col == cols - COL_W'(1)) begin
                col <= '0;
                row <= row + ROW_W'(1);
            end else begin
                col <= col + COL_W'(1);
            end
        end
    end

    assert_col_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col < cols);
    assert_step_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !busy);
endmodule

// File: rtl/spd_sym_parser.sv
// Symbol parser: reads the bitstream one bit per cycle and walks the
// type bit, the nibble-count field and the count nibbles. It starts skips
// in the tracker and emits one nonzero when a value is present and the
// output stage can take it. It stops after nnz emissions and then flushes
// the feeder. Assumes nnz is stable during a decode.
module spd_sym_parser #(
    parameter int NNZ_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NNZ_W-1:0]          nnz,
    input  logic                      bit_avail,
    input  logic                      bit_val,
    output logic                      take,
    output logic                      flush,
    input  logic                      trk_busy,
    output logic                      load,
    output logic [spd_pkg::RUN_W-1:0] load_amt,
    input  logic                      data_valid,
    input  logic                      out_free,
    output logic                      emit,
    output logic                      finished
);
    import spd_pkg::*;

    pstate_t           state_q;
    logic [LEN_W-2:0]  field_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic [RUN_W-2:0]  run_q;
    logic [NNZ_W-1:0]  emitted_q;
    logic              more;
    logic [LEN_W-1:0]  len_next;

    assign more     = (emitted_q != nnz);
    assign len_next = {field_q, bit_val};
    assign load_amt = {run_q, bit_val};
    assign finished = (state_q == PS_DONE);

    // Decide which bit is consumed and which side effect fires this cycle.
    always_comb begin
        take  = 1'b0;
        emit  = 1'b0;
        load  = 1'b0;
        flush = 1'b0;
        case (state_q)
            PS_TYPE: take = bit_avail && more;
            PS_HDR:  take = bit_avail;
            PS_CNT: begin
                take = bit_avail;
                load = bit_avail && (fcnt_q == FCNT_W'(1));
            end
            PS_EMIT: emit = data_valid && out_free;
            PS_DONE: flush = 1'b1;
            default: ;
        endcase
    end

    // Step the symbol state machine and its field counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PS_TYPE;
            field_q   <= '0;
            fcnt_q    <= '0;
            run_q     <= '0;
            emitted_q <= '0;
        end else begin
            case (state_q)
                PS_TYPE: begin
                    if (!more) begin
                        state_q <= PS_DONE;
                    end else if (bit_avail) begin
                        state_q <= bit_val ? PS_EMIT : PS_HDR;
                        fcnt_q  <= FCNT_W'(LEN_W);
                        field_q <= '0;
                    end
                end
                PS_HDR: begin
                    if (bit_avail) begin
                        field_q <= len_next[LEN_W-2:0];
                        fcnt_q  <= fcnt_q - FCNT_W'(1);
                        if (fcnt_q == FCNT_W'(1)) begin
                            state_q <= PS_CNT;
                            fcnt_q  <= (FCNT_W'(len_next) + FCNT_W'(1)) << 2;
                            run_q   <= '0;
                        end
                    end
                end
                PS_CNT: begin
                    if (bit_avail) begin
                        run_q  <= {run_q[RUN_W-3:0], bit_val};
                        fcnt_q <= fcnt_q - FCNT_W'(1);
                        if (fcnt_q == FCNT_W'(1)) begin
                            state_q <= PS_SKIP;
                        end
                    end
                end
                PS_SKIP: begin
                    if (!trk_busy) begin
                        state_q <= PS_TYPE;
                    end
                end
                PS_EMIT: begin
                    if (emit) begin
                        emitted_q <= emitted_q + NNZ_W'(1);
                        state_q   <= PS_TYPE;
                    end
                end
                default: state_q <= PS_DONE;
            endcase
        end
    end

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> finished);
    assert_emit_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (emitted_q < nnz));
    assert_no_take_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> !take);
endmodule

// File: rtl/spd_out_stage.sv
// Output stage: one tuple register with a valid flag. It captures row,
// column and value on emit and holds them until the consumer accepts.
// Assumes emit is only raised when out_free is high.
module spd_out_stage #(
    parameter int ROW_W  = 32,
    parameter int COL_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] data,
    output logic              out_free,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic [DATA_W-1:0] out_data
);
    assign out_free = !out_valid || out_ready;

    // Capture a new tuple or retire the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_col   <= '0;
            out_data  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_row   <= row;
            out_col   <= col;
            out_data  <= data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)
            && $stable(out_col) && $stable(out_data)));
    assert_emit_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> out_free);
endmodule

// File: rtl/sparse_mark_decoder.sv
// Top level: decodes a packed zero/nonzero marker bitstream into
// (row, column, value) tuples. The feeder serialises words, the parser
// reads symbols, the tracker keeps the position and the output stage holds
// each tuple. Assumes cfg_cols is nonzero and both configuration inputs
// are stable from reset release until done.
module sparse_mark_decoder #(
    parameter int WORD_W = 16,
    parameter int ROW_W  = 32,
    parameter int COL_W  = 16,
    parameter int NNZ_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [NNZ_W-1:0]  cfg_nnz,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              data_valid,
    output logic              data_ready,
    input  logic [DATA_W-1:0] data_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic [DATA_W-1:0] out_data,
    output logic              done
);
    import spd_pkg::*;

    logic             bit_avail, bit_val, take, flush;
    logic             trk_busy, load, emit, out_free, finished;
    logic [RUN_W-1:0] load_amt;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    spd_bit_feeder #(.WORD_W(WORD_W)) u_feed (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .take(take), .flush(flush),
        .bit_avail(bit_avail), .bit_val(bit_val)
    );

    spd_sym_parser #(.NNZ_W(NNZ_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .nnz(cfg_nnz),
        .bit_avail(bit_avail), .bit_val(bit_val),
        .take(take), .flush(flush),
        .trk_busy(trk_busy), .load(load), .load_amt(load_amt),
        .data_valid(data_valid), .out_free(out_free),
        .emit(emit), .finished(finished)
    );

    spd_pos_tracker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_track (
        .clk(clk), .rst_n(rst_n), .cols(cfg_cols),
        .load(load), .load_amt(load_amt), .step(emit),
        .busy(trk_busy), .row(cur_row), .col(cur_col)
    );

    spd_out_stage #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .emit(emit),
        .row(cur_row), .col(cur_col), .data(data_in),
        .out_free(out_free), .out_valid(out_valid), .out_ready(out_ready),
        .out_row(out_row), .out_col(out_col), .out_data(out_data)
    );

    assign data_ready = emit;
    assign done       = finished && !out_valid;

    assert_pop_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_ready) |=> out_valid);
    assert_pop_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> data_valid);
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !out_valid));
endmodule

// File: tb/tb_sparse_mark_decoder.sv
module tb_sparse_mark_decoder;
    localparam int WORD_W = 16;
    localparam int ROW_W  = 32;
    localparam int COL_W  = 16;
    localparam int NNZ_W  = 32;
    localparam int DATA_W = 16;
    localparam int MAXNZ  = 4;

    // Scenario table: column count, nonzero count, and per nonzero the
    // zero gap before it with the nibble width used (0 = no zero symbol).
    localparam int NC = 4;
    localparam int C_COLS [NC] = '{4, 5, 3, 65535};
    localparam int C_NNZ  [NC] = '{4, 3, 2, 2};
    localparam int C_GAP  [NC*MAXNZ] = '{0, 0, 0, 0,
                                         3, 7, 0, 0,
                                         20, 1, 0, 0,
                                         32'h7FFF_FFF0, 0, 0, 0};
    localparam int C_NIB  [NC*MAXNZ] = '{0, 0, 0, 0,
                                         1, 1, 2, 0,
                                         2, 1, 0, 0,
                                         8, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [COL_W-1:0]  cfg_cols = '0;
    logic [NNZ_W-1:0]  cfg_nnz = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [WORD_W-1:0] in_data = '0;
    logic              data_valid = 1'b0;
    logic              data_ready;
    logic [DATA_W-1:0] data_in = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [ROW_W-1:0]  out_row;
    logic [COL_W-1:0]  out_col;
    logic [DATA_W-1:0] out_data;
    logic              done;

    always #4 clk = ~clk;

    sparse_mark_decoder #(.WORD_W(WORD_W), .ROW_W(ROW_W), .COL_W(COL_W),
                          .NNZ_W(NNZ_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_nnz(cfg_nnz),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .data_valid(data_valid), .data_ready(data_ready), .data_in(data_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .out_col(out_col), .out_data(out_data), .done(done)
    );

    int errors = 0;
    int checks = 0;
    int total_cyc = 0;
    logic [WORD_W-1:0] words [16];
    int nwords;
    longint exp_row [MAXNZ];
    longint exp_col [MAXNZ];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Encode scenario c into packed words and compute expected positions.
    task automatic build(input int c);
        logic bits [0:255];
        int nb = 0;
        longint seq = 0;
        for (int i = 0; i < 256; i++) bits[i] = 1'b1;
        for (int i = 0; i < C_NNZ[c]; i++) begin
            int g = C_GAP[c*MAXNZ+i];
            int n = C_NIB[c*MAXNZ+i];
            if (n != 0) begin
                int len = n - 1;
                bits[nb] = 1'b0; nb++;
                for (int b = 2; b >= 0; b--) begin bits[nb] = len[b]; nb++; end
                for (int b = n*4-1; b >= 0; b--) begin bits[nb] = g[b]; nb++; end
            end
            bits[nb] = 1'b1; nb++;
            seq = seq + longint'(g);
            exp_row[i] = seq / C_COLS[c];
            exp_col[i] = seq % C_COLS[c];
            seq = seq + 1;
        end
        nwords = (nb + WORD_W - 1) / WORD_W;
        for (int w = 0; w < 16; w++) begin
            for (int b = 0; b < WORD_W; b++) words[w][WORD_W-1-b] = bits[w*WORD_W+b];
        end
    endtask

    task automatic do_reset(input int cols, input int nnz);
        rst_n = 1'b0;
        in_valid = 1'b0; data_valid = 1'b0; out_ready = 1'b0;
        cfg_cols = COL_W'(cols);
        cfg_nnz = NNZ_W'(nnz);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run one table scenario with stalled value and output handshakes.
    task automatic run_case(input int c, input string tag);
        int wi = 0, di = 0, ti = 0, cyc = 0;
        bit held = 0;
        logic [ROW_W-1:0] hr; logic [COL_W-1:0] hc; logic [DATA_W-1:0] hd;
        build(c);
        do_reset(C_COLS[c], C_NNZ[c]);
        if (c == 0) begin
            #1;
            check(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
            check(done == 1'b0, "R9", "done after reset", longint'(done), 0);
            check(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);
            check(data_ready == 1'b0, "R9", "data_ready after reset", longint'(data_ready), 0);
        end
        while (1) begin
            @(posedge clk);
            @(negedge clk);
            cyc++; total_cyc++;
            in_valid = 1'b1;
            in_data = (wi < 16) ? words[wi] : '1;
            data_valid = ((cyc % 3) != 1);
            data_in = DATA_W'(16'hA0 + di);
            out_ready = (((cyc + c) % 4) != 0);
            #1;
            if (held && out_valid) begin
                check(out_row == hr && out_col == hc && out_data == hd, "R6",
                      "tuple held while stalled", longint'(out_col), longint'(hc));
            end
            held = out_valid && !out_ready;
            hr = out_row; hc = out_col; hd = out_data;
            if (out_valid && out_ready) begin
                if (ti < C_NNZ[c]) begin
                    check(longint'(out_row) == exp_row[ti], tag, "row", longint'(out_row), exp_row[ti]);
                    check(longint'(out_col) == exp_col[ti], tag, "col", longint'(out_col), exp_col[ti]);
                    check(out_data == DATA_W'(16'hA0 + ti), "R5", "paired value",
                          longint'(out_data), longint'(16'hA0 + ti));
                end else begin
                    check(1'b0, "R7", "extra tuple index", ti, C_NNZ[c]);
                end
                ti++;
            end
            if (in_valid && in_ready) wi++;
            if (data_valid && data_ready) di++;
            if (done) break;
            if (cyc > 60000 || total_cyc > 190000) begin
                check(1'b0, "R7", "watchdog expired in scenario", c, -1);
                break;
            end
        end
        check(ti == C_NNZ[c], "R7", "tuple count", ti, C_NNZ[c]);
        check(di == C_NNZ[c], "R5", "values taken", di, C_NNZ[c]);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            #1;
            if (!done || out_valid || in_ready || data_ready) begin
                check(1'b0, "R7", "state after done", longint'({done, out_valid, in_ready}), 4);
            end
        end
        check(done && !in_ready, "R7", "done sticky and input closed",
              longint'({done, in_ready}), 2);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            string tag;
            case (c)
                0: tag = "R1 R2";
                1: tag = "R1 R3";
                2: tag = "R4";
                default: tag = "R10";
            endcase
            run_case(c, tag);
        end

        // R8: zero nonzeros; done with no tuple and no value taken.
        begin
            int pops = 0, tuples = 0;
            do_reset(4, 0);
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                in_valid = 1'b1; in_data = 16'hFFFF;
                data_valid = 1'b1; out_ready = 1'b1;
                #1;
                if (data_ready) pops++;
                if (out_valid) tuples++;
            end
            check(done == 1'b1, "R8", "done with zero count", longint'(done), 1);
            check(pops == 0, "R8", "values taken", pops, 0);
            check(tuples == 0, "R8", "tuples seen", tuples, 0);
            check(in_ready == 1'b0, "R8", "input closed", longint'(in_ready), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule